// File: doc/BRIEF.md
# Shared Queue RAM Test-Access Controller

This block sits in front of one single-port RAM that is carved into three queues laid end to end: an asynchronous transmit queue, an isochronous transmit queue and a general receive queue. Each RAM word is 33 bits wide. The top bit is a control marker and the lower 32 bits are data. In normal operation the queue logic reaches the RAM through a plain word port. A host register interface can switch the block into a test mode. In that mode the queue port is stalled and the host reaches any RAM word through one data register and a pointer.

In test mode, each data access goes to the word that the pointer selects, and the pointer then steps by one. The pointer wraps from the last word back to zero. Software can load the pointer, clear it, and choose the control bit that test writes store. The stored control bit is never read back as a plain data bit. A test read compares it with the software-chosen bit and raises a sticky mismatch flag when the two differ. A second status register previews the control bit of the word at the pointer before that word is read.

Top module: `fifo_ramtest_ctrl`

## Requirements
- R1: After reset, test mode, the write control bit, the mismatch flag and the pointer are all 0, `q_stall` is low and `hst_rvalid` is low.
- R2: The test-status register sits at byte address 20h, with test mode at bit 5. `q_stall` equals that bit. While it is 1, queue-port writes leave the RAM unchanged.
- R3: In test mode, a host write to address C0h stores {test-status bit 4, write data} into the word at the pointer, and the pointer then advances by one.
- R4: Every host read (with `hst_wr` low) raises `hst_rvalid` for exactly the next cycle, with the data in that cycle. In test mode, a read of C0h returns bits 31:0 of the word at the pointer, and the pointer then advances by one.
- R5: A write to the test-status register loads the pointer from bits 16 upward (ceil(log2(total words)) bits). A value past the last word loads 0. Pointer steps wrap from the last word to 0, and the pointer reads back in the same field.
- R6: A test-status write with bit 3 set clears the pointer to 0 and clears the mismatch flag. Bit 3 reads back as 0.
- R7: A test read whose stored control bit differs from test-status bit 4 sets the mismatch flag (test-status bit 2). The flag then stays set until it is cleared, and further test accesses proceed normally.
- R8: In test mode, bit 1 of a read of byte address 30h gives the control bit of the word at the pointer. All other bits read 0, and the pointer does not move.
- R9: Outside test mode, a host write to C0h changes neither the RAM nor the pointer, and a read of C0h returns 0.
- R10: `atx_base` is 0, `itx_base` equals the asynchronous queue size, and `grx_base` equals the sum of the two transmit queue sizes.
- R11: Outside test mode, the queue port writes the 33-bit word at `nq_addr`. It also reads that word, which appears on `nq_rdata` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 8 | Host register byte address |
| hst_wr | input | 1 | Host write strobe (wins over read) |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid with hst_rvalid |
| hst_rvalid | output | 1 | Read data valid, one cycle after the read |
| nq_en | input | 1 | Queue-port access request |
| nq_we | input | 1 | Queue-port write select |
| nq_addr | input | AW | Queue-port word address |
| nq_wdata | input | 33 | Queue-port write word |
| nq_rdata | output | 33 | Queue-port read word |
| q_stall | output | 1 | High while test mode holds the RAM |
| atx_base | output | AW | First word of the asynchronous transmit queue |
| itx_base | output | AW | First word of the isochronous transmit queue |
| grx_base | output | AW | First word of the receive queue |

## Verification
The bench uses the default sizes of 16, 8 and 16 words, so the RAM holds 40 words behind a 6-bit pointer. Because 40 is not a power of two, the bench can reach the wrap from word 39 to 0. It can also load pointer values 40 to 63, which must fall back to 0. The control bit of each word is chosen at random, so random reads hit both the matching and the mismatching case, with the sticky flag checked across later reads and clears.

// File: rtl/fifo_rt_pkg.sv
// Shared constants for the queue RAM test-access controller.
// Assumes an 8-bit host byte address and a 32-bit host data path.
package fifo_rt_pkg;
    localparam logic [7:0] OFS_TSTAT = 8'h20;
    localparam logic [7:0] OFS_RSTAT = 8'h30;
    localparam logic [7:0] OFS_DATA  = 8'hC0;
    localparam int B_TEST   = 5;
    localparam int B_CTRL1  = 4;
    localparam int B_CLR    = 3;
    localparam int B_MISM   = 2;
    localparam int B_PEEK   = 1;
    localparam int PTR_LSB  = 16;
    typedef enum logic [1:0] {RS_NONE, RS_TSTAT, RS_RSTAT, RS_DATA} rsel_e;
endpackage

// File: rtl/rt_regs.sv
// Test-status state: mode enable, write control bit, sticky mismatch flag
// and the auto-stepping pointer. Assumes DEPTH <= 2**AW and AW <= 16.
module rt_regs
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 40,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_wr,
    input  logic [31:0]   st_wdata,
    input  logic          step,
    input  logic          mm_set,
    output logic          test_en,
    output logic          ctrl1,
    output logic          mm_flag,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   LIM  = (AW+1)'(DEPTH);

    logic [AW-1:0] load_v;
    logic          load_ok;
    logic          clr_req;

    // Decode the pointer load value and the clear request.
    always_comb begin
        load_v  = st_wdata[PTR_LSB +: AW];
        load_ok = {1'b0, load_v} < LIM;
        clr_req = st_wr && st_wdata[B_CLR];
    end

    // Mode bits and pointer: a register write takes priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_en <= 1'b0;
            ctrl1   <= 1'b0;
            ptr     <= '0;
        end else if (st_wr) begin
            test_en <= st_wdata[B_TEST];
            ctrl1   <= st_wdata[B_CTRL1];
            ptr     <= (clr_req || !load_ok) ? '0 : load_v;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // Sticky mismatch flag, cleared only by the clear request.
    always_ff @(posedge clk) begin
        if (!rst_n)       mm_flag <= 1'b0;
        else if (clr_req) mm_flag <= 1'b0;
        else if (mm_set)  mm_flag <= 1'b1;
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, ptr} < LIM);                                             // R5
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_wr && !step) |=> $stable(ptr));                            // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_flag && !clr_req) |=> mm_flag);                             // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (ptr == '0 && !mm_flag));                           // R6
endmodule

// File: rtl/rt_ram.sv
// Single-port synchronous RAM with one-cycle read latency.
// Assumes no reset of contents; out-of-range writes are dropped and
// out-of-range reads return zero.
module rt_ram #(
    parameter int DEPTH = 40,
    parameter int AW    = 6,
    parameter int W     = 33
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam logic [AW:0] LIM = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic         in_rng;

    // Range check on the shared address.
    always_comb in_rng = {1'b0, addr} < LIM;

    // One access per cycle: write, or registered read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                if (in_rng) mem[addr] <= wdata;
            end else begin
                rdata <= in_rng ? mem[addr] : '0;
            end
        end
    end
endmodule

// File: rtl/rt_portmux.sv
// Chooses who drives the RAM port: the test path while test mode is on,
// the queue port otherwise. Assumes the test path reads every idle cycle
// so the word at the pointer is always previewed.
module rt_portmux #(
    parameter int AW = 6,
    parameter int W  = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en,
    input  logic          t_we,
    input  logic [W-1:0]  t_wdata,
    input  logic [AW-1:0] ptr,
    input  logic          nq_en,
    input  logic          nq_we,
    input  logic [AW-1:0] nq_addr,
    input  logic [W-1:0]  nq_wdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [W-1:0]  ram_wdata
);
    // Port selection by mode.
    always_comb begin
        if (test_en) begin
            ram_en    = 1'b1;
            ram_we    = t_we;
            ram_addr  = ptr;
            ram_wdata = t_wdata;
        end else begin
            ram_en    = nq_en;
            ram_we    = nq_en && nq_we;
            ram_addr  = nq_addr;
            ram_wdata = nq_wdata;
        end
    end

    AST_STALL_GATES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && nq_en && nq_we && !t_we) |-> !ram_we);              // R2
endmodule

// File: rtl/fifo_ramtest_ctrl.sv
// Top: host register decode, read-return path, mismatch detection and
// queue base outputs around one shared queue RAM.
// Assumes one host access per cycle; a write wins over a read.
module fifo_ramtest_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int  ATX_WORDS = 16,
    parameter int  ITX_WORDS = 8,
    parameter int  GRX_WORDS = 16,
    localparam int TOTAL     = ATX_WORDS + ITX_WORDS + GRX_WORDS,
    localparam int AW        = $clog2(TOTAL),
    localparam int W         = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    hst_addr,
    input  logic          hst_wr,
    input  logic          hst_rd,
    input  logic [31:0]   hst_wdata,
    output logic [31:0]   hst_rdata,
    output logic          hst_rvalid,
    input  logic          nq_en,
    input  logic          nq_we,
    input  logic [AW-1:0] nq_addr,
    input  logic [W-1:0]  nq_wdata,
    output logic [W-1:0]  nq_rdata,
    output logic          q_stall,
    output logic [AW-1:0] atx_base,
    output logic [AW-1:0] itx_base,
    output logic [AW-1:0] grx_base
);
    logic          test_en, ctrl1, mm_flag, mm_set;
    logic [AW-1:0] ptr;
    logic          rd_go, st_wr, t_we, t_rd, step;
    rsel_e         rsel;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [W-1:0]  ram_wdata, ram_q;
    logic [31:0]   tstat_view;

    // Host strobe decode.
    always_comb begin
        rd_go = hst_rd && !hst_wr;
        st_wr = hst_wr && (hst_addr == OFS_TSTAT);
        t_we  = hst_wr && (hst_addr == OFS_DATA) && test_en;
        t_rd  = rd_go  && (hst_addr == OFS_DATA) && test_en;
        step  = t_we || t_rd;
    end

    rt_regs #(.DEPTH(TOTAL), .AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_wdata(hst_wdata),
        .step(step), .mm_set(mm_set), .test_en(test_en), .ctrl1(ctrl1),
        .mm_flag(mm_flag), .ptr(ptr)
    );

    rt_portmux #(.AW(AW), .W(W)) i_mux (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .t_we(t_we),
        .t_wdata({ctrl1, hst_wdata}), .ptr(ptr), .nq_en(nq_en),
        .nq_we(nq_we), .nq_addr(nq_addr), .nq_wdata(nq_wdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata)
    );

    rt_ram #(.DEPTH(TOTAL), .AW(AW), .W(W)) i_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_q)
    );

    // Remember which register the pending read returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_rvalid <= 1'b0;
            rsel       <= RS_NONE;
        end else begin
            hst_rvalid <= rd_go;
            if (!rd_go)                                  rsel <= RS_NONE;
            else if (hst_addr == OFS_TSTAT)              rsel <= RS_TSTAT;
            else if (hst_addr == OFS_RSTAT && test_en)   rsel <= RS_RSTAT;
            else if (hst_addr == OFS_DATA && test_en)    rsel <= RS_DATA;
            else                                         rsel <= RS_NONE;
        end
    end

    // Assemble the live test-status word.
    always_comb begin
        tstat_view                   = '0;
        tstat_view[PTR_LSB +: AW]    = ptr;
        tstat_view[B_TEST]           = test_en;
        tstat_view[B_CTRL1]          = ctrl1;
        tstat_view[B_MISM]           = mm_flag;
    end

    // Read-return mux.
    always_comb begin
        hst_rdata = '0;
        case (rsel)
            RS_TSTAT: hst_rdata = tstat_view;
            RS_RSTAT: hst_rdata[B_PEEK] = ram_q[W-1];
            RS_DATA:  hst_rdata = ram_q[31:0];
            default:  hst_rdata = '0;
        endcase
    end

    // Control-bit compare on returning test data.
    always_comb mm_set = hst_rvalid && (rsel == RS_DATA) && (ram_q[W-1] != ctrl1);

    // Queue-side outputs and fixed layout.
    always_comb begin
        nq_rdata = ram_q;
        q_stall  = test_en;
        atx_base = '0;
        itx_base = AW'(ATX_WORDS);
        grx_base = AW'(ATX_WORDS + ITX_WORDS);
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        hst_rvalid |-> $past(hst_rd && !hst_wr));                       // R4
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rvalid && rsel == RS_NONE) |-> (hst_rdata == '0));         // R9
    AST_PEEK_ONLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rvalid && rsel == RS_RSTAT) |-> ((hst_rdata & ~32'h2) == '0)); // R8
endmodule

// File: tb/test_fifo_ramtest_ctrl.sv
module test_fifo_ramtest_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 40;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic        hst_wr = 1'b0, hst_rd = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_rvalid;
    logic        nq_en = 1'b0, nq_we = 1'b0;
    logic [AW-1:0] nq_addr = '0;
    logic [32:0] nq_wdata = '0;
    logic [32:0] nq_rdata;
    logic        q_stall;
    logic [AW-1:0] atx_base, itx_base, grx_base;

    fifo_ramtest_ctrl i_fifo_ramtest_ctrl (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_rvalid(hst_rvalid), .nq_en(nq_en), .nq_we(nq_we),
        .nq_addr(nq_addr), .nq_wdata(nq_wdata), .nq_rdata(nq_rdata),
        .q_stall(q_stall), .atx_base(atx_base), .itx_base(itx_base),
        .grx_base(grx_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0;
    logic [32:0] m_mem [DEPTH];
    int   m_ptr = 0;
    bit   m_test = 0, m_c1 = 0, m_flag = 0;
    logic [31:0] rd_val;

    task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_tstat();
        return (32'(m_ptr) << 16) | (32'(m_test) << 5) | (32'(m_c1) << 4) | (32'(m_flag) << 2);
    endfunction

    function automatic int next_ptr(input int p);
        return (p == DEPTH-1) ? 0 : p + 1;
    endfunction

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk); hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, input string req, output logic [31:0] d);
        @(negedge clk); hst_addr = a; hst_rd = 1'b1;
        @(negedge clk); hst_rd = 1'b0;
        chk(hst_rvalid === 1'b1, req, {32'd0, hst_rvalid}, 33'd1);
        d = hst_rdata;
    endtask

    // Status write that also updates the model.
    task automatic set_stat(input bit t, input bit c1, input bit clr, input int p);
        hwrite(8'h20, (32'(p) << 16) | (32'(t) << 5) | (32'(c1) << 4) | (32'(clr) << 3));
        m_test = t; m_c1 = c1;
        if (clr) begin m_ptr = 0; m_flag = 0; end
        else m_ptr = (p < DEPTH) ? p : 0;
    endtask

    task automatic t_write(input logic [31:0] d);
        hwrite(8'hC0, d);
        m_mem[m_ptr] = {m_c1, d};
        m_ptr = next_ptr(m_ptr);
    endtask

    task automatic t_read(input string req);
        logic [31:0] v;
        hread(8'hC0, req, v);
        chk(v === m_mem[m_ptr][31:0], req, {1'b0, v}, {1'b0, m_mem[m_ptr][31:0]});
        if (m_mem[m_ptr][32] != m_c1) m_flag = 1;
        m_ptr = next_ptr(m_ptr);
    endtask

    task automatic stat_chk(input string req);
        logic [31:0] v;
        hread(8'h20, req, v);
        chk(v === exp_tstat(), req, {1'b0, v}, {1'b0, exp_tstat()});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(q_stall === 1'b0, "R1", {32'd0, q_stall}, 33'd0);
        chk(hst_rvalid === 1'b0, "R1", {32'd0, hst_rvalid}, 33'd0);
        stat_chk("R1");
        // R10 queue bases
        chk(atx_base === 6'd0, "R10", {27'd0, atx_base}, 33'd0);
        chk(itx_base === 6'd16, "R10", {27'd0, itx_base}, 33'd16);
        chk(grx_base === 6'd24, "R10", {27'd0, grx_base}, 33'd24);
        // R11 queue port in normal mode
        for (int i = 0; i < 4; i++) begin
            logic [32:0] w;
            int a;
            w = {1'($urandom), $urandom};
            a = 3 + i * 9;
            @(negedge clk); nq_en = 1; nq_we = 1; nq_addr = AW'(a); nq_wdata = w;
            @(negedge clk); nq_we = 0;
            @(negedge clk); nq_en = 0;
            chk(nq_rdata === w, "R11", nq_rdata, w);
        end
        // R9 data read outside test mode returns 0
        hread(8'hC0, "R9", rd_val);
        chk(rd_val === 32'd0, "R9", {1'b0, rd_val}, 33'd0);
        // R2 enter test mode, R3 fill every word
        set_stat(1, 0, 0, 0);
        chk(q_stall === 1'b1, "R2", {32'd0, q_stall}, 33'd1);
        for (int i = 0; i < DEPTH; i++) begin
            set_stat(1, 1'($urandom), 0, i);
            t_write($urandom);
        end
        stat_chk("R5");   // pointer wrapped to 0 after the last word
        set_stat(1, 0, 1, 0);
        // R9 leave test mode, C0 write ignored, pointer untouched
        set_stat(0, 0, 0, 7);
        hwrite(8'hC0, 32'hDEAD_BEEF);
        stat_chk("R9");
        // R11 queue read sees the word stored by the test path
        @(negedge clk); nq_en = 1; nq_we = 0; nq_addr = 6'd7;
        @(negedge clk); nq_en = 0;
        chk(nq_rdata === m_mem[7], "R11", nq_rdata, m_mem[7]);
        // R2 queue write while stalled is dropped
        set_stat(1, m_mem[7][32], 0, 7);
        @(negedge clk); nq_en = 1; nq_we = 1; nq_addr = 6'd7; nq_wdata = 33'h1_2345_6789;
        @(negedge clk); nq_en = 0; nq_we = 0;
        t_read("R2");
        t_read("R9");
        // R5 out-of-range load and wrap from last word
        set_stat(1, 0, 0, 63);
        stat_chk("R5");
        set_stat(1, m_mem[DEPTH-1][32], 0, DEPTH-1);
        t_read("R4");
        stat_chk("R5");
        // R7 forced mismatch then immediate further read, R6 clear
        set_stat(1, ~m_mem[5][32], 0, 5);
        t_read("R7");
        t_read("R7");
        stat_chk("R7");
        set_stat(1, 0, 1, 20);
        stat_chk("R6");
        // R8 peek directed
        begin
            logic [31:0] v;
            set_stat(1, 0, 0, 11);
            hread(8'h30, "R8", v);
            chk(v === {30'd0, m_mem[11][32], 1'b0}, "R8", {1'b0, v}, {31'd0, m_mem[11][32], 1'b0});
            stat_chk("R8");
        end
        // Random mix of test-mode operations
        for (int n = 0; n < 500; n++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3) t_write($urandom);
            else if (op < 6) t_read("R4");
            else if (op == 6) set_stat(1, 1'($urandom), ($urandom % 6) == 0, int'($urandom % 64));
            else if (op == 7) stat_chk("R7");
            else begin
                logic [31:0] v;
                hread(8'h30, "R8", v);
                chk(v === {30'd0, m_mem[m_ptr][32], 1'b0}, "R8", {1'b0, v}, {31'd0, m_mem[m_ptr][32], 1'b0});
            end
        end
        stat_chk("R3");
        set_stat(0, 0, 0, 0);
        chk(q_stall === 1'b0, "R2", {32'd0, q_stall}, 33'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule